// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block holds the pending-cause and enable-mask state for a 32-source interrupt group and drives one level interrupt toward the bus side of a chip. Hardware sources deliver single-cycle event pulses, one line per source, and these latch into a cause register. Software acknowledges causes by writing ones to the cause register. It never writes the mask directly. Instead it writes ones to a set register to enable sources and writes ones to a separate clear register to disable them, so several agents can change disjoint mask bits without a read-modify-write race.

Access goes through a simple register port with address, write strobe, write data, read strobe and read data. Read data is combinational and is valid in the same cycle as the read strobe. The interrupt output is a registered level: it is high when some source is both enabled and pending. An `irq_allow` gate is provided as the attachment point for a later rate limiter; when held low, it forces the next output level low. Only the sources at bits 15:0, 20, 22 and 30:24 exist. All other bit positions are reserved.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A write to offset 0x880 sets every live mask bit whose write-data bit is 1. Mask bits written with 0 keep their value. A read of 0x880 returns the mask, where 1 means enabled.
- R2: A write to offset 0x888 clears every mask bit whose write-data bit is 1. Bits written with 0 keep their value. Offset 0x888 is write-only and reads as 0.
- R3: Read data is combinational. It returns the cause register at 0x800 and the mask at 0x880. It is 0 at any other offset, and it is 0 whenever `reg_rd` is low.
- R4: A synchronous active-high reset clears the mask, the cause register and `irq_out`, so every source is disabled.
- R5: Reserved bit positions are 31, 23, 21 and 19:16. They ignore writes and event pulses and always read as 0 in both the mask and the cause register. The live bits are 15:0, 20, 22 and 30:24, which together form the value 0x7F50FFFF.
- R6: An event pulse on a live bit of `evt_pulse` sets that cause bit at the next edge. Writing 1 to a bit at 0x800 clears that cause bit. Writing 0 to a bit at 0x800 leaves that bit unchanged.
- R7: When an event pulse and a cause-clear write hit the same bit in one cycle, the bit ends set.
- R8: At each clock edge, `irq_out` takes the value of (mask AND cause is nonzero) AND `irq_allow`, using the values just before that edge. A mask or cause change therefore shows on `irq_out` one cycle later.
- R9: If `irq_allow` is low at an edge, `irq_out` is low after that edge, whatever the mask and cause hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W (12) | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W (32) | Combinational read data |
| evt_pulse | input | DATA_W (32) | Per-source single-cycle event pulses |
| irq_allow | input | 1 | Gate for the output level, the attachment point for a rate limiter |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 12-bit offset and the live-bit map 0x7F50FFFF. With these values every reserved position (bit 31, bit 23, bit 21 and bits 19:16) can be reached by all-ones writes and all-ones event vectors. Directed steps cover the zero-write cases, an event colliding with a cause clear, and the one-cycle output latency. They also cover the effect of the allow gate. Long random sequences then mix writes, reads, unmapped offsets and sparse events, and compare each result against a bench model.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;

    localparam int REG_ADDR_W = 12;
    localparam int REG_DATA_W = 32;

    localparam logic [31:0] OFS_CAUSE = 32'h0000_0800;
    localparam logic [31:0] OFS_MSET  = 32'h0000_0880;
    localparam logic [31:0] OFS_MCLR  = 32'h0000_0888;

    // Live sources: 15:0 queues, 20 link, 22 mgmt, 27:24 pins, 28..30 errors/timer
    localparam logic [31:0] LIVE_BITS = 32'h7F50_FFFF;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    typedef struct packed {
        logic cause_w1c;
        logic mask_set;
        logic mask_clr;
    } wr_strobe_t;

    function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
        if (ofs == OFS_CAUSE)     return SEL_CAUSE;
        else if (ofs == OFS_MSET) return SEL_MSET;
        else if (ofs == OFS_MCLR) return SEL_MCLR;
        else                      return SEL_NONE;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_mask_pkg::*;
#(
    parameter int ADDR_W = REG_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output wr_strobe_t        stb,
    output reg_sel_e          rd_sel
);
    reg_sel_e sel;

    always_comb begin
        sel           = decode_ofs(32'(addr));
        stb.cause_w1c = wr && (sel == SEL_CAUSE);
        stb.mask_set  = wr && (sel == SEL_MSET);
        stb.mask_clr  = wr && (sel == SEL_MCLR);
        rd_sel        = rd ? sel : SEL_NONE;
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] LIVE   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mask_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)                      bit_q <= 1'b0;
                else if (clr_stb && wdata[i]) bit_q <= 1'b0;
                else if (set_stb && wdata[i]) bit_q <= 1'b1;
            end
            assign mask_q[i] = bit_q;
        end else begin : g_rsvd
            assign mask_q[i] = 1'b0;
        end
    end

    assert_mask_set_R1: assert property (@(posedge clk) disable iff (rst)
        (set_stb && !clr_stb) |=> ((mask_q & $past(wdata & LIVE)) == $past(wdata & LIVE)));

    assert_mask_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(mask_q));

    assert_mask_clr_R2: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] LIVE   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w1c_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] evt,
    output logic [DATA_W-1:0] cause_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (LIVE[i]) begin : g_live
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)                      bit_q <= 1'b0;
                else if (evt[i])              bit_q <= 1'b1;
                else if (w1c_stb && wdata[i]) bit_q <= 1'b0;
            end
            assign cause_q[i] = bit_q;
        end else begin : g_rsvd
            assign cause_q[i] = 1'b0;
        end
    end

    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((cause_q & $past(evt & LIVE)) == $past(evt & LIVE)));

    assert_cause_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (w1c_stb && evt == '0) |=> ((cause_q & $past(wdata)) == '0));

    assert_cause_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!w1c_stb && evt == '0) |=> $stable(cause_q));
endmodule

// File: rtl/irq_level_out.sv
module irq_level_out #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] cause,
    input  logic              allow,
    output logic              irq
);
    logic hit;
    assign hit = |(mask & cause);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= hit && allow;
    end

    assert_irq_needs_hit_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(mask & cause) != '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !allow |=> !irq);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irq_mask_pkg::*;
#(
    parameter int                ADDR_W     = REG_ADDR_W,
    parameter int                DATA_W     = REG_DATA_W,
    parameter logic [DATA_W-1:0] LIVE_MASK  = DATA_W'(LIVE_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] evt_pulse,
    input  logic              irq_allow,
    output logic              irq_out
);
    wr_strobe_t        stb;
    reg_sel_e          rd_sel;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] cause_q;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .stb    (stb),
        .rd_sel (rd_sel)
    );

    irq_mask_bank #(.DATA_W(DATA_W), .LIVE(LIVE_MASK)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .set_stb (stb.mask_set),
        .clr_stb (stb.mask_clr),
        .wdata   (reg_wdata),
        .mask_q  (mask_q)
    );

    irq_cause_bank #(.DATA_W(DATA_W), .LIVE(LIVE_MASK)) u_cause (
        .clk     (clk),
        .rst     (rst),
        .w1c_stb (stb.cause_w1c),
        .wdata   (reg_wdata),
        .evt     (evt_pulse),
        .cause_q (cause_q)
    );

    irq_level_out #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .mask  (mask_q),
        .cause (cause_q),
        .allow (irq_allow),
        .irq   (irq_out)
    );

    always_comb begin
        unique case (rd_sel)
            SEL_CAUSE: reg_rdata = cause_q;
            SEL_MSET:  reg_rdata = mask_q;
            default:   reg_rdata = '0;
        endcase
    end

    assert_rdata_rsvd_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_MASK) == '0);

    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> (reg_rdata == '0));

    assert_reset_clear_R4: assert property (@(posedge clk)
        rst |=> (!irq_out && mask_q == '0 && cause_q == '0));
endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] LIVE = 32'h7F50_FFFF;
    localparam logic [11:0] A_CAUSE = 12'h800;
    localparam logic [11:0] A_MSET  = 12'h880;
    localparam logic [11:0] A_MCLR  = 12'h888;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_pulse = '0;
    logic        irq_allow = 1'b1;
    logic        irq_out;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    logic [31:0] m_mask = '0;
    logic [31:0] m_cause = '0;
    logic        m_irq = 1'b0;
    logic [31:0] last_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_mask_ctrl dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq_allow(irq_allow), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic r);
        if (!r) return 32'h0;
        if (a == A_CAUSE) return m_cause;
        if (a == A_MSET)  return m_mask;
        return 32'h0;
    endfunction

    // One bus cycle: drive at negedge, check read data, then check the irq level after the edge
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic r, input logic [31:0] e, input logic al, input string tag);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d; reg_rd = r; evt_pulse = e; irq_allow = al;
        #1;
        last_rd = reg_rdata;
        if (r) chk({tag, " rdata R3"}, reg_rdata, model_read(a, r));
        @(posedge clk);
        m_irq = ((m_mask & m_cause) != 0) && al;
        if (w && a == A_MSET)  m_mask = m_mask | (d & LIVE);
        if (w && a == A_MCLR)  m_mask = m_mask & ~d;
        if (w && a == A_CAUSE) m_cause = m_cause & ~d;
        m_cause = (m_cause | e) & LIVE;
        #1;
        chk({tag, " irq R8"}, {31'h0, irq_out}, {31'h0, m_irq});
    endtask

    task automatic idle(input logic al, input string tag);
        cyc(12'h000, 1'b0, 32'h0, 1'b0, 32'h0, al, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R4: reset state
        cyc(A_MSET, 0, 0, 1, 0, 1, "R4");
        chk("R4 mask after reset", last_rd, 32'h0);
        cyc(A_CAUSE, 0, 0, 1, 0, 1, "R4");
        chk("R4 cause after reset", last_rd, 32'h0);
        chk("R4 irq after reset", {31'h0, irq_out}, 32'h0);

        // R1 / R5: all-ones set lands only on live bits
        cyc(A_MSET, 1, 32'hFFFF_FFFF, 0, 0, 1, "R1");
        cyc(A_MSET, 0, 0, 1, 0, 1, "R5");
        chk("R5 mask reserved bits", last_rd, 32'h7F50_FFFF);
        cyc(A_MSET, 1, 32'h0, 0, 0, 1, "R1");
        cyc(A_MSET, 0, 0, 1, 0, 1, "R1");
        chk("R1 zero set write", last_rd, 32'h7F50_FFFF);

        // R2: clear register
        cyc(A_MCLR, 1, 32'h0, 0, 0, 1, "R2");
        cyc(A_MSET, 0, 0, 1, 0, 1, "R2");
        chk("R2 zero clear write", last_rd, 32'h7F50_FFFF);
        cyc(A_MCLR, 1, 32'h0000_000F, 0, 0, 1, "R2");
        cyc(A_MSET, 0, 0, 1, 0, 1, "R2");
        chk("R2 clear low nibble", last_rd, 32'h7F50_FFF0);
        cyc(A_MCLR, 0, 0, 1, 0, 1, "R2");
        chk("R2 clear reg reads zero", last_rd, 32'h0);

        // R3: unmapped offset
        cyc(12'h123, 0, 0, 1, 0, 1, "R3");
        chk("R3 unmapped read", last_rd, 32'h0);

        // R5 / R6: events
        cyc(12'h000, 0, 0, 0, 32'hFFFF_FFFF, 1, "R6");
        cyc(A_CAUSE, 0, 0, 1, 0, 1, "R6");
        chk("R6 R5 cause after events", last_rd, 32'h7F50_FFFF);
        chk("R8 irq with hit", {31'h0, irq_out}, 32'h1);

        // R7: event beats same-cycle clear on bit 0
        cyc(A_CAUSE, 1, 32'hFFFF_FFFF, 0, 32'h0000_0001, 1, "R7");
        cyc(A_CAUSE, 0, 0, 1, 0, 1, "R7");
        chk("R7 event wins", last_rd, 32'h0000_0001);
        chk("R8 irq low no overlap", {31'h0, irq_out}, 32'h0);

        // R8: one-cycle latency after enabling bit 0
        cyc(A_MSET, 1, 32'h0000_0001, 0, 0, 1, "R8");
        chk("R8 irq latency", {31'h0, irq_out}, 32'h0);
        idle(1, "R8");
        chk("R8 irq rises", {31'h0, irq_out}, 32'h1);

        // R9: gate
        idle(0, "R9");
        chk("R9 gated low", {31'h0, irq_out}, 32'h0);
        idle(1, "R9");
        chk("R9 ungated", {31'h0, irq_out}, 32'h1);

        // R6: acknowledge; level drops one cycle later
        cyc(A_CAUSE, 1, 32'h0000_0001, 0, 0, 1, "R6");
        idle(1, "R6");
        chk("R6 irq after ack", {31'h0, irq_out}, 32'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            logic        w;
            logic [31:0] e;
            case ($urandom_range(0, 4))
                0: a = A_CAUSE;
                1: a = A_MSET;
                2: a = A_MCLR;
                3: a = A_MSET;
                default: a = 12'($urandom);
            endcase
            w = $urandom_range(0, 1) == 1;
            e = ($urandom_range(0, 3) == 0) ? ($urandom & $urandom & $urandom) : 32'h0;
            cyc(a, w, $urandom, !w, e, $urandom_range(0, 9) != 0, "RND R1 R2 R6");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule